// File: doc/BRIEF.md
# Multiplexed Asynchronous 32-bit Bus Master

This block is the host-side controller that runs one 32-bit transfer over a shared set of 32 lines. Each transfer has two phases. In the first phase the lines carry the address. In the second phase they carry the data. The CPU side presents a request with a write flag, a longword address, four byte enables and write data. When the transfer is over, it gets back read data and a one-cycle done strobe, or an error strobe if the transfer was abandoned.

The bus side is fully interlocked and has no fixed timing. The peripheral ends each phase with an edge on a single acknowledge line:
- a falling edge closes the address phase;
- a rising edge closes the data phase.

The acknowledge input passes through a two-flop synchronizer, and edges are detected on the synchronized copy. The legacy 8-bit data strobe output is never asserted. A programmable watchdog limit abandons a transfer if an acknowledge edge never arrives.

The state machine has six states:
- IDLE: waits for a request.
- ADDR_SETUP: drives the address word with the strobe still high.
- ADDR_WAIT: holds the address strobe low until acknowledge falls.
- DATA_SETUP: turns the lines around. It drives write data, or releases the lines for a read.
- DATA_WAIT: holds the data strobe low until acknowledge rises.
- CLOSE: waits for the synchronized acknowledge to be high before returning to IDLE.

The transitions are:
- IDLE→ADDR_SETUP on a request.
- ADDR_SETUP→ADDR_WAIT unconditionally.
- ADDR_WAIT→DATA_SETUP on a falling acknowledge.
- ADDR_WAIT→CLOSE on watchdog expiry.
- DATA_SETUP→DATA_WAIT unconditionally.
- DATA_WAIT→CLOSE on a rising acknowledge, which completes the transfer.
- DATA_WAIT→CLOSE on watchdog expiry, which aborts the transfer.
- CLOSE→IDLE once acknowledge is high.

Top module: `mux_bus_master`

## Requirements
- R1: After reset, both strobes (`as_n`, `ds_n`) are high, `bus_oe` is 0, and `done` and `err` are 0.
- R2: The address word carries the longword address in bits [22:0] and the byte enables in bits [26:23], with bit 23 as byte lane 0. Bits [31:27] are zero. The word is driven with `bus_oe`=1 for at least one cycle before `as_n` falls. `rw_n` is 0 for a write and 1 for a read.
- R3: `as_n` stays low, with the address still driven, until a falling edge of `ack_n` is seen.
- R4: After the acknowledge falls, a write drives `wdata` on the bus and a read releases it (`bus_oe`=0). `ds_n` then goes low, and this happens only while `as_n` is low.
- R5: `ds_n` stays low until a rising edge of `ack_n` is seen.
- R6: On the rising edge, both strobes return high, the bus is released and `done` pulses for one cycle. For a read, `rdata` holds the full 32-bit bus value whatever the byte enables were.
- R7: `legacy_ds_n` is high at all times.
- R8: If an awaited acknowledge edge does not arrive within `wdog_limit` cycles, the transfer aborts. Both strobes rise, the bus is released, `err` pulses for one cycle and `done` stays 0.
- R9: After a transfer ends or aborts, no new request is started while `ack_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Transfer request, sampled in IDLE |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 23 | Longword address (byte address bits 2..24) |
| be | input | 4 | Byte enables, bit 0 = lane 0 |
| wdata | input | 32 | Write data |
| wdog_limit | input | 16 | Cycles allowed per acknowledge wait |
| rdata | output | 32 | Read data captured at end of data phase |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | One-cycle abort strobe |
| bus_out | output | 32 | Value driven on the shared lines |
| bus_oe | output | 1 | Drive enable for the shared lines |
| bus_in | input | 32 | Value sensed on the shared lines |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | 32-bit data strobe, active low |
| rw_n | output | 1 | 1 = read, 0 = write |
| legacy_ds_n | output | 1 | Legacy 8-bit data strobe, kept inactive |
| ack_n | input | 1 | Handshake acknowledge from the peripheral |

## Verification
The hardest case to reach is an abort in the data phase that leaves acknowledge stuck low. In that case the master must keep refusing a pending request until the line returns high.

The bench builds this case by answering the address phase with a falling acknowledge and then never raising it, so the watchdog expires. It keeps a request asserted for many cycles and checks that the address strobe never falls. It then releases acknowledge and confirms that the held request starts promptly and completes.

A second hard case is a slave that waits a long time before each edge. The bench uses such delays to show that both strobes hold as long as the slave asks.

// File: rtl/mbm_pkg.sv
package mbm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR_SETUP,
        ST_ADDR_WAIT,
        ST_DATA_SETUP,
        ST_DATA_WAIT,
        ST_CLOSE
    } mbm_state_e;
endpackage

// File: rtl/ack_sync.sv
module ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_n_async,
    output logic ack_s,
    output logic ack_fall,
    output logic ack_rise
);
    // STAGES synchronizer flops plus one history flop for edge detection
    logic [STAGES:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg <= '1;
        else        shreg <= {shreg[STAGES-1:0], ack_n_async};
    end

    assign ack_s    = shreg[STAGES-1];
    assign ack_fall = shreg[STAGES] & ~shreg[STAGES-1];
    assign ack_rise = ~shreg[STAGES] & shreg[STAGES-1];
endmodule

// File: rtl/phase_watchdog.sv
module phase_watchdog #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    assign expired = active && (cnt >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (!active)  cnt <= '0;
        else if (!expired) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/mux_bus_master.sv
module mux_bus_master
    import mbm_pkg::*;
#(
    parameter int ADDR_W      = 23,
    parameter int DATA_W      = 32,
    parameter int BE_W        = 4,
    parameter int SYNC_STAGES = 2,
    parameter int WDOG_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] wdata,
    input  logic [WDOG_W-1:0] wdog_limit,
    output logic [DATA_W-1:0] rdata,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    input  logic [DATA_W-1:0] bus_in,
    output logic              as_n,
    output logic              ds_n,
    output logic              rw_n,
    output logic              legacy_ds_n,
    input  logic              ack_n
);
    localparam int PAD_W = DATA_W - ADDR_W - BE_W;

    mbm_state_e state, state_nx;

    logic [ADDR_W-1:0] addr_q;
    logic [BE_W-1:0]   be_q;
    logic [DATA_W-1:0] wdata_q;
    logic              we_q;
    logic              ack_s, ack_fall, ack_rise;
    logic              wd_active, wd_expired;
    logic [DATA_W-1:0] addr_word;

    ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_n_async (ack_n),
        .ack_s       (ack_s),
        .ack_fall    (ack_fall),
        .ack_rise    (ack_rise)
    );

    assign wd_active = (state == ST_ADDR_WAIT) || (state == ST_DATA_WAIT);

    phase_watchdog #(.CNT_W(WDOG_W)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (wd_active),
        .limit   (wdog_limit),
        .expired (wd_expired)
    );

    assign addr_word = {{PAD_W{1'b0}}, be_q, addr_q};

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:       if (req) state_nx = ST_ADDR_SETUP;
            ST_ADDR_SETUP: state_nx = ST_ADDR_WAIT;
            ST_ADDR_WAIT: begin
                if (ack_fall)        state_nx = ST_DATA_SETUP;
                else if (wd_expired) state_nx = ST_CLOSE;
            end
            ST_DATA_SETUP: state_nx = ST_DATA_WAIT;
            ST_DATA_WAIT: begin
                if (ack_rise)        state_nx = ST_CLOSE;
                else if (wd_expired) state_nx = ST_CLOSE;
            end
            ST_CLOSE:      if (ack_s) state_nx = ST_IDLE;
            default:       state_nx = ST_IDLE;
        endcase
    end

    // state register and transfer bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            addr_q  <= '0;
            be_q    <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
            rdata   <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            state <= state_nx;
            done  <= (state == ST_DATA_WAIT) && ack_rise;
            err   <= wd_expired &&
                     (((state == ST_ADDR_WAIT) && !ack_fall) ||
                      ((state == ST_DATA_WAIT) && !ack_rise));
            if ((state == ST_IDLE) && req) begin
                addr_q  <= addr;
                be_q    <= be;
                wdata_q <= wdata;
                we_q    <= we;
            end
            if ((state == ST_DATA_WAIT) && ack_rise && !we_q)
                rdata <= bus_in;
        end
    end

    // output decode
    always_comb begin
        as_n        = 1'b1;
        ds_n        = 1'b1;
        rw_n        = 1'b1;
        bus_oe      = 1'b0;
        bus_out     = '0;
        legacy_ds_n = 1'b1;
        unique case (state)
            ST_IDLE, ST_CLOSE: ;
            ST_ADDR_SETUP: begin
                rw_n    = ~we_q;
                bus_oe  = 1'b1;
                bus_out = addr_word;
            end
            ST_ADDR_WAIT: begin
                as_n    = 1'b0;
                rw_n    = ~we_q;
                bus_oe  = 1'b1;
                bus_out = addr_word;
            end
            ST_DATA_SETUP: begin
                as_n    = 1'b0;
                rw_n    = ~we_q;
                bus_oe  = we_q;
                bus_out = we_q ? wdata_q : '0;
            end
            ST_DATA_WAIT: begin
                as_n    = 1'b0;
                ds_n    = 1'b0;
                rw_n    = ~we_q;
                bus_oe  = we_q;
                bus_out = we_q ? wdata_q : '0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mbm_checker.sv
module mbm_checker (
    input logic clk,
    input logic rst_n,
    input logic as_n,
    input logic ds_n,
    input logic rw_n,
    input logic bus_oe,
    input logic done,
    input logic err
);
    // address is on the lines before and when the strobe falls
    assert_addr_before_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(as_n) |-> bus_oe && $past(bus_oe));

    // data strobe only inside the address strobe window
    assert_ds_inside_as_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ds_n |-> !as_n);

    // read data phase leaves the lines free; write data phase drives them
    assert_turnaround_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ds_n |-> (bus_oe == !rw_n));

    // completion leaves both strobes idle and the bus released
    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> as_n && ds_n && !bus_oe);

    // abort leaves both strobes idle and never pairs with done
    assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> as_n && ds_n && !bus_oe && !done);

    // done is a single-cycle pulse
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind mux_bus_master mbm_checker u_mbm_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .as_n   (as_n),
    .ds_n   (ds_n),
    .rw_n   (rw_n),
    .bus_oe (bus_oe),
    .done   (done),
    .err    (err)
);

// File: tb/test_mux_bus_master.sv
module test_mux_bus_master;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [22:0] addr = '0;
    logic [3:0]  be = '0;
    logic [31:0] wdata = '0;
    logic [15:0] wdog_limit = 16'd200;
    logic [31:0] rdata;
    logic        done, err;
    logic [31:0] bus_out;
    logic        bus_oe;
    logic [31:0] bus_in = 32'hDEAD_0000;
    logic        as_n, ds_n, rw_n, legacy_ds_n;
    logic        ack_n = 1'b1;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mux_bus_master i_mux_bus_master (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .be(be),
        .wdata(wdata), .wdog_limit(wdog_limit), .rdata(rdata), .done(done),
        .err(err), .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in),
        .as_n(as_n), .ds_n(ds_n), .rw_n(rw_n), .legacy_ds_n(legacy_ds_n),
        .ack_n(ack_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // legacy strobe watched on every falling edge: R7
    always @(negedge clk) begin
        cycles++;
        if (rst_n && legacy_ds_n !== 1'b1) begin
            fails++;
            $display("FAIL R7 legacy strobe actual=%b expected=1", legacy_ds_n);
        end
        if (cycles > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    typedef struct packed {
        logic        we;
        logic [3:0]  be;
        logic [22:0] addr;
        logic [31:0] wdata;
        logic [31:0] rval;
        logic [3:0]  dly;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{1'b1, 4'b1111, 23'h000001, 32'h1234_5678, 32'h0,          4'd1},
        '{1'b0, 4'b0001, 23'h7FFFFF, 32'h0,          32'hCAFE_F00D, 4'd0},
        '{1'b1, 4'b0101, 23'h2AAAAA, 32'hA5A5_5A5A, 32'h0,          4'd7},
        '{1'b0, 4'b0000, 23'h555555, 32'h0,          32'hFFFF_FFFF, 4'd3},
        '{1'b1, 4'b1000, 23'h000000, 32'h0000_0001, 32'h0,          4'd12},
        '{1'b0, 4'b1111, 23'h123456, 32'h0,          32'h0BAD_BEEF, 4'd9}
    };

    task automatic run_xfer(input vec_t v);
        int n;
        @(negedge clk);
        req = 1'b1; we = v.we; addr = v.addr; be = v.be; wdata = v.wdata;
        n = 0;
        while (as_n !== 1'b0 && n < 50) begin
            @(negedge clk); n++;
            // R2: address driven while strobe still high
            if (as_n === 1'b1 && bus_oe === 1'b1)
                chk(bus_out == {5'b0, v.be, v.addr}, "R2 setup word", bus_out,
                    {5'b0, v.be, v.addr});
        end
        req = 1'b0;
        chk(as_n == 1'b0, "R2 as_n low", {31'b0, as_n}, 32'd0);
        chk(bus_oe == 1'b1 && bus_out == {5'b0, v.be, v.addr}, "R2 address word",
            bus_out, {5'b0, v.be, v.addr});
        chk(rw_n == !v.we, "R2 rw_n", {31'b0, rw_n}, {31'b0, !v.we});
        chk(ds_n == 1'b1, "R4 ds_n high in address phase", {31'b0, ds_n}, 32'd1);
        for (int i = 0; i < v.dly; i++) @(negedge clk);
        chk(as_n == 1'b0 && bus_oe == 1'b1, "R3 address held", {30'b0, as_n, bus_oe},
            32'd1);
        ack_n = 1'b0;
        n = 0;
        while (ds_n !== 1'b0 && n < 50) begin @(negedge clk); n++; end
        chk(ds_n == 1'b0 && as_n == 1'b0, "R4 ds_n low inside as_n",
            {30'b0, as_n, ds_n}, 32'd0);
        chk(bus_oe == v.we, "R4 turnaround", {31'b0, bus_oe}, {31'b0, v.we});
        if (v.we) chk(bus_out == v.wdata, "R4 write data", bus_out, v.wdata);
        bus_in = v.rval;
        for (int i = 0; i < v.dly; i++) @(negedge clk);
        chk(ds_n == 1'b0, "R5 ds_n held", {31'b0, ds_n}, 32'd0);
        ack_n = 1'b1;
        n = 0;
        while (done !== 1'b1 && n < 50) begin @(negedge clk); n++; end
        chk(done == 1'b1, "R6 done", {31'b0, done}, 32'd1);
        chk(as_n == 1'b1 && ds_n == 1'b1 && bus_oe == 1'b0, "R6 release",
            {29'b0, as_n, ds_n, bus_oe}, 32'd6);
        if (!v.we) chk(rdata == v.rval, "R6 read data", rdata, v.rval);
        bus_in = 32'h5555_0000;
        @(negedge clk);
        chk(done == 1'b0, "R6 done pulse width", {31'b0, done}, 32'd0);
        @(negedge clk);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(as_n == 1 && ds_n == 1 && bus_oe == 0 && done == 0 && err == 0,
            "R1 reset", {27'b0, as_n, ds_n, bus_oe, done, err}, 32'h18);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(as_n == 1 && ds_n == 1 && bus_oe == 0, "R1 idle after reset",
            {29'b0, as_n, ds_n, bus_oe}, 32'd6);

        foreach (VEC[k]) run_xfer(VEC[k]);

        // R8: no acknowledge in address phase
        wdog_limit = 16'd20;
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = 23'h11; be = 4'hF;
        n = 0;
        while (as_n !== 1'b0 && n < 50) begin @(negedge clk); n++; end
        req = 1'b0;
        n = 0;
        while (err !== 1'b1 && n < 100) begin
            @(negedge clk); n++;
            if (done === 1'b1) chk(0, "R8 no done on abort", 32'd1, 32'd0);
        end
        chk(err == 1'b1, "R8 abort in address phase", {31'b0, err}, 32'd1);
        chk(as_n == 1 && ds_n == 1 && bus_oe == 0, "R8 release after abort",
            {29'b0, as_n, ds_n, bus_oe}, 32'd6);
        chk(n >= 18, "R8 abort not early", n, 32'd18);

        // R8 + R9: acknowledge falls but never rises
        repeat (3) @(negedge clk);
        req = 1'b1; we = 1'b1; addr = 23'h22; be = 4'h3; wdata = 32'h77;
        n = 0;
        while (as_n !== 1'b0 && n < 50) begin @(negedge clk); n++; end
        req = 1'b0;
        ack_n = 1'b0;
        n = 0;
        while (err !== 1'b1 && n < 100) begin @(negedge clk); n++; end
        chk(err == 1'b1, "R8 abort in data phase", {31'b0, err}, 32'd1);
        chk(done == 1'b0, "R8 no done", {31'b0, done}, 32'd0);
        req = 1'b1; we = 1'b0; addr = 23'h33; be = 4'h1;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (as_n !== 1'b1) chk(0, "R9 held off while ack low", {31'b0, as_n}, 32'd1);
        end
        chk(as_n == 1'b1, "R9 no start while ack low", {31'b0, as_n}, 32'd1);
        ack_n = 1'b1;
        n = 0;
        while (as_n !== 1'b0 && n < 20) begin @(negedge clk); n++; end
        req = 1'b0;
        chk(as_n == 1'b0 && bus_out == {5'b0, 4'h1, 23'h33}, "R9 start after ack high",
            bus_out, {5'b0, 4'h1, 23'h33});
        bus_in = 32'h0000_ABCD;
        ack_n = 1'b0;
        n = 0;
        while (ds_n !== 1'b0 && n < 50) begin @(negedge clk); n++; end
        ack_n = 1'b1;
        n = 0;
        while (done !== 1'b1 && n < 50) begin @(negedge clk); n++; end
        chk(done == 1'b1 && rdata == 32'h0000_ABCD, "R6 read after recovery", rdata,
            32'h0000_ABCD);

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule